// File: doc/BRIEF.md
# Row Splitting Pixel Packer

The block sits between a sensor receiver and a memory writer. Every 64-bit input word holds four 16-bit pixel slots, two pixels of an even sensor row and two of the next odd row, interleaved by column. The block sends the two rows down separate byte lanes, so that software never has to untangle the columns. In the 12-bit and 10-bit modes it packs each pixel pair into three bytes, which cuts memory traffic by a quarter. In the 14-bit mode each pixel keeps a two-byte container.

Each row lane has its own byte accumulator. A 64-bit output word leaves a lane as soon as eight bytes have gathered there. Words carry a row-parity flag, so a downstream address generator can place the two rows in separate buffers. An end-of-line marker on an input word flushes what is left in both lanes. A short final word is zero-padded, and a byte count tells how much of it is real. Both edges use valid/ready handshakes, and a stalled output holds the input off.

Top module: `row_split_packer`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: Input slots `in_data[15:0]` and `[31:16]` are pixels 0 and 1 of the even row, and `[47:32]` and `[63:48]` are pixels 0 and 1 of the odd row. Even-row bytes appear only in words with `out_odd`=0, and odd-row bytes only in words with `out_odd`=1, each lane keeping the input order.
- R3: With `mode` 00 or 11 (14-bit), each pixel adds two bytes in this order: slot[7:0], then {2'b00, slot[13:8]}. Slot bits 15:14 are ignored.
- R4: With `mode` 01 (12-bit), a pixel pair A,B adds three bytes: A[11:4], {A[3:0], B[11:8]}, B[7:0]. Slot bits 15:12 are ignored.
- R5: With `mode` 10 (10-bit), each pixel is first widened to {slot[9:0], 2'b00} and the pair is then packed as in R4.
- R6: The first byte of a lane goes to `out_data[7:0]` and later bytes go to higher byte lanes. A full word, with `out_bytes`=8, is emitted whenever a lane holds eight bytes.
- R7: Words leave in pairs: an even-row word (`out_odd`=0) is always followed by an odd-row word (`out_odd`=1) from the same set of input words.
- R8: An input word with `in_eol`=1 empties both lanes after its own bytes are added. A final word holding fewer than eight bytes is zero-padded above `out_bytes`. The last word of each lane for the line has `out_last`=1, and every other word has `out_last`=0.
- R9: While `out_valid` is high and `out_ready` is low, the output word and its sideband stay stable. `in_ready` is low whenever a word is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can take an input word |
| in_data | input | 64 | Four 16-bit pixel slots, even row low, odd row high |
| in_eol | input | 1 | Word is the last of a line pair |
| mode | input | 2 | Pixel depth: 00/11 14-bit, 01 12-bit, 10 10-bit |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream takes the output word |
| out_data | output | 64 | Packed bytes, first byte lowest |
| out_odd | output | 1 | Word belongs to the odd row |
| out_bytes | output | 4 | Number of valid bytes in the word (1 to 8) |
| out_last | output | 1 | Final word of this row for the line |

## Verification
The hardest case to reach is a line that ends while a lane holds more than eight bytes. That happens only when a three- or four-byte append lands on a lane that is nearly full, and it forces one full word and one short word out of each lane in a single flush. Directed lines of chosen length and depth reach this case, along with the exact-eight flush. Random lines with a random depth per line, random line ends and a random `out_ready` then cover the other fill levels, while stalls land on every word position.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
   typedef enum logic [1:0] {
      PK_W14  = 2'b00,
      PK_W12  = 2'b01,
      PK_W10  = 2'b10,
      PK_W14B = 2'b11
   } pix_mode_e;

   localparam int unsigned ROWS = 2;
endpackage

// File: rtl/rsp_pixel_pack.sv
module rsp_pixel_pack
   import rsp_pkg::*;
#(
   parameter int unsigned SLOT_W = 16,
   parameter int unsigned PAIR_BYTES = 4,
   localparam int unsigned NB_W = $clog2(PAIR_BYTES + 1)
) (
   input  logic [1:0]              mode,
   input  logic [SLOT_W-1:0]       pix_a,
   input  logic [SLOT_W-1:0]       pix_b,
   output logic [8*PAIR_BYTES-1:0] bytes_o,
   output logic [NB_W-1:0]         nbytes_o
);
   generate
      if (SLOT_W < 14) begin : g_bad_slot
         $error("SLOT_W must hold a 14-bit pixel");
      end
      if (PAIR_BYTES != 4) begin : g_bad_pair
         $error("PAIR_BYTES must be 4");
      end
   endgenerate

   logic [11:0] a12, b12;

   always_comb begin
      a12      = pix_a[11:0];
      b12      = pix_b[11:0];
      bytes_o  = '0;
      nbytes_o = NB_W'(3);
      case (pix_mode_e'(mode))
         PK_W10: begin
            a12 = {pix_a[9:0], 2'b00};
            b12 = {pix_b[9:0], 2'b00};
         end
         default: ;
      endcase
      case (pix_mode_e'(mode))
         PK_W12, PK_W10: begin
            bytes_o[7:0]   = a12[11:4];
            bytes_o[15:8]  = {a12[3:0], b12[11:8]};
            bytes_o[23:16] = b12[7:0];
            nbytes_o       = NB_W'(3);
         end
         default: begin
            bytes_o[7:0]   = pix_a[7:0];
            bytes_o[15:8]  = {2'b00, pix_a[13:8]};
            bytes_o[23:16] = pix_b[7:0];
            bytes_o[31:24] = {2'b00, pix_b[13:8]};
            nbytes_o       = NB_W'(4);
         end
      endcase
   end
endmodule

// File: rtl/rsp_row_accum.sv
module rsp_row_accum #(
   parameter int unsigned OUT_BYTES = 8,
   parameter int unsigned APP_BYTES = 4,
   localparam int unsigned BUF_BYTES = 2 * OUT_BYTES,
   localparam int unsigned CNT_W = $clog2(BUF_BYTES + 1),
   localparam int unsigned NB_W = $clog2(APP_BYTES + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   app_en,
   input  logic [8*APP_BYTES-1:0] app_data,
   input  logic [NB_W-1:0]        app_n,
   input  logic                   pop_en,
   output logic [8*OUT_BYTES-1:0] word_o,
   output logic [CNT_W-1:0]       cnt_o
);
   generate
      if (APP_BYTES > OUT_BYTES) begin : g_bad_app
         $error("APP_BYTES must not exceed OUT_BYTES");
      end
   endgenerate

   logic [BUF_BYTES-1:0][7:0] store_q;
   logic [CNT_W-1:0]          cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         store_q <= '0;
         cnt_q   <= '0;
      end else if (pop_en) begin
         if (cnt_q >= CNT_W'(OUT_BYTES)) begin
            store_q <= store_q >> (8 * OUT_BYTES);
            cnt_q   <= cnt_q - CNT_W'(OUT_BYTES);
         end else begin
            store_q <= '0;
            cnt_q   <= '0;
         end
      end else if (app_en) begin
         for (int i = 0; i < APP_BYTES; i++) begin
            if (NB_W'(i) < app_n) begin
               store_q[cnt_q + CNT_W'(i)] <= app_data[8*i +: 8];
            end
         end
         cnt_q <= cnt_q + CNT_W'(app_n);
      end
   end

   assign word_o = store_q[OUT_BYTES-1:0];
   assign cnt_o  = cnt_q;

   // R8: the lane never holds more than one word plus one append
   assert_room_R8: assert property (@(posedge clk) disable iff (!rst_n)
      app_en |-> ({1'b0, cnt_q} + (CNT_W+1)'(app_n)) <= (CNT_W+1)'(BUF_BYTES));

   // R9: a lane is never filled and drained in the same cycle
   assert_no_app_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(app_en && pop_en));
endmodule

// File: rtl/row_split_packer.sv
module row_split_packer
   import rsp_pkg::*;
#(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned SLOT_W = 16,
   localparam int unsigned SLOTS = DATA_W / SLOT_W,
   localparam int unsigned OUT_BYTES = DATA_W / 8,
   localparam int unsigned APP_BYTES = 2 * SLOT_W / 8,
   localparam int unsigned NB_W = $clog2(APP_BYTES + 1),
   localparam int unsigned CNT_W = $clog2(2 * OUT_BYTES + 1),
   localparam int unsigned BYTES_W = $clog2(OUT_BYTES + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [DATA_W-1:0]  in_data,
   input  logic               in_eol,
   input  logic [1:0]         mode,
   output logic               out_valid,
   input  logic               out_ready,
   output logic [DATA_W-1:0]  out_data,
   output logic               out_odd,
   output logic [BYTES_W-1:0] out_bytes,
   output logic               out_last
);
   generate
      if (SLOTS != 2 * ROWS) begin : g_bad_slots
         $error("input word must carry two pixels per row");
      end
      if (SLOT_W != 16 || DATA_W % 8 != 0) begin : g_bad_width
         $error("pixel slots must be 16 bits in a byte-aligned word");
      end
   endgenerate

   logic [ROWS-1:0][DATA_W-1:0]      word_w;
   logic [ROWS-1:0][CNT_W-1:0]       cnt_w;
   logic [ROWS-1:0][8*APP_BYTES-1:0] pk_bytes;
   logic [ROWS-1:0][NB_W-1:0]        pk_n;
   logic [ROWS-1:0]                  pop_w;

   logic             emit_q, sel_q, flush_q;
   logic             accept, out_fire;
   logic [CNT_W-1:0] sum_cnt, cur_cnt, rem_cnt;

   assign accept   = in_valid && in_ready;
   assign out_fire = out_valid && out_ready;

   generate
      for (genvar r = 0; r < ROWS; r++) begin : g_row
         rsp_pixel_pack #(
            .SLOT_W     (SLOT_W),
            .PAIR_BYTES (APP_BYTES)
         ) u_pack (
            .mode     (mode),
            .pix_a    (in_data[(2*r)*SLOT_W +: SLOT_W]),
            .pix_b    (in_data[(2*r+1)*SLOT_W +: SLOT_W]),
            .bytes_o  (pk_bytes[r]),
            .nbytes_o (pk_n[r])
         );

         assign pop_w[r] = out_fire && (sel_q == 1'(r));

         rsp_row_accum #(
            .OUT_BYTES (OUT_BYTES),
            .APP_BYTES (APP_BYTES)
         ) u_accum (
            .clk      (clk),
            .rst_n    (rst_n),
            .app_en   (accept),
            .app_data (pk_bytes[r]),
            .app_n    (pk_n[r]),
            .pop_en   (pop_w[r]),
            .word_o   (word_w[r]),
            .cnt_o    (cnt_w[r])
         );
      end
   endgenerate

   assign sum_cnt = cnt_w[0] + CNT_W'(pk_n[0]);
   assign cur_cnt = cnt_w[sel_q];
   assign rem_cnt = (cur_cnt >= CNT_W'(OUT_BYTES)) ? cur_cnt - CNT_W'(OUT_BYTES) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         emit_q  <= 1'b0;
         sel_q   <= 1'b0;
         flush_q <= 1'b0;
      end else if (accept) begin
         flush_q <= in_eol;
         sel_q   <= 1'b0;
         emit_q  <= (sum_cnt >= CNT_W'(OUT_BYTES)) || (in_eol && sum_cnt != '0);
      end else if (out_fire) begin
         if (!sel_q) begin
            sel_q <= 1'b1;
         end else begin
            sel_q  <= 1'b0;
            emit_q <= (rem_cnt >= CNT_W'(OUT_BYTES)) || (flush_q && rem_cnt != '0);
         end
      end
   end

   assign in_ready  = !emit_q;
   assign out_valid = emit_q;
   assign out_data  = word_w[sel_q];
   assign out_odd   = sel_q;
   assign out_bytes = (cur_cnt >= CNT_W'(OUT_BYTES)) ? BYTES_W'(OUT_BYTES) : BYTES_W'(cur_cnt);
   assign out_last  = flush_q && (cur_cnt <= CNT_W'(OUT_BYTES));

   // R9: a stalled word holds still
   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_odd)
                                  && $stable(out_bytes) && $stable(out_last));

   // R7: an even word is always followed by its odd partner
   assert_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_fire && !out_odd |=> out_valid && out_odd);

   // R8: short words only at the end of a line
   assert_partial_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_bytes != BYTES_W'(OUT_BYTES) |-> out_last);

   // R8: the last odd word of a line leaves both lanes empty
   assert_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_fire && out_odd && out_last |=> cnt_w[0] == '0 && cnt_w[1] == '0 && !out_valid);

   // R2: the two lanes fill and drain in lockstep
   assert_lockstep_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> cnt_w[0] == cnt_w[1]);
endmodule

// File: tb/row_split_packer_tb.sv
module row_split_packer_tb;
   localparam int CLK_PERIOD = 10;

   typedef struct {
      logic [63:0] d;
      logic        odd;
      int          nb;
      logic        last;
      string       tag;
   } exp_t;

   typedef struct {
      logic [63:0] d;
      logic        eol;
      logic [1:0]  mode;
   } stim_t;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid, in_ready, in_eol, out_valid, out_ready, out_odd, out_last;
   logic [63:0] in_data, out_data;
   logic [1:0]  mode;
   logic [3:0]  out_bytes;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   exp_t        exp_q[$];
   stim_t       stim_q[$];
   logic [7:0]  lane0[$];
   logic [7:0]  lane1[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   row_split_packer u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_data   (in_data),
      .in_eol    (in_eol),
      .mode      (mode),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_data  (out_data),
      .out_odd   (out_odd),
      .out_bytes (out_bytes),
      .out_last  (out_last)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] pk_bytes(input logic [1:0] m, input logic [15:0] a,
                                            input logic [15:0] b);
      logic [11:0] a12, b12;
      a12 = (m == 2'b10) ? {a[9:0], 2'b00} : a[11:0];
      b12 = (m == 2'b10) ? {b[9:0], 2'b00} : b[11:0];
      if (m == 2'b01 || m == 2'b10)
         return {8'h00, b12[7:0], a12[3:0], b12[11:8], a12[11:4]};
      return {2'b00, b[13:8], b[7:0], 2'b00, a[13:8], a[7:0]};
   endfunction

   function automatic int pk_n(input logic [1:0] m);
      return (m == 2'b01 || m == 2'b10) ? 3 : 4;
   endfunction

   function automatic string mode_tag(input logic [1:0] m);
      case (m)
         2'b01:   return "R4";
         2'b10:   return "R5";
         default: return "R3";
      endcase
   endfunction

   task automatic take(ref logic [7:0] q[$], input logic odd, input logic eol, input string tag);
      exp_t e;
      int   sz;
      sz     = q.size();
      e.nb   = (sz >= 8) ? 8 : sz;
      e.d    = '0;
      for (int k = 0; k < e.nb; k++) e.d[8*k +: 8] = q.pop_front();
      e.odd  = odd;
      e.last = eol && (sz <= 8);
      e.tag  = tag;
      exp_q.push_back(e);
   endtask

   task automatic model_accept(input logic [63:0] w, input logic eol, input logic [1:0] m);
      logic [31:0] b0, b1;
      b0 = pk_bytes(m, w[15:0], w[31:16]);
      b1 = pk_bytes(m, w[47:32], w[63:48]);
      for (int k = 0; k < pk_n(m); k++) begin
         lane0.push_back(b0[8*k +: 8]);
         lane1.push_back(b1[8*k +: 8]);
      end
      while (lane0.size() >= 8 || (eol && lane0.size() > 0)) begin
         take(lane0, 1'b0, eol, mode_tag(m));
         take(lane1, 1'b1, eol, mode_tag(m));
      end
   endtask

   task automatic push_stim(input logic [63:0] d, input logic eol, input logic [1:0] m);
      stim_t s;
      s.d = d; s.eol = eol; s.mode = m;
      stim_q.push_back(s);
   endtask

   task automatic run(input int vpct, input int rpct, input int max_cycles);
      bit          hold_pend = 0;
      logic [63:0] hold_d = '0;
      logic [4:0]  hold_side = '0;
      bit          took = 0;
      int          idle = 0;
      exp_t        e;
      stim_t       s;
      for (int c = 0; c < max_cycles; c++) begin
         @(negedge clk);
         if (took) begin in_valid = 1'b0; took = 0; end
         if (!in_valid && stim_q.size() > 0 && $urandom_range(0, 99) < vpct) begin
            s        = stim_q.pop_front();
            in_data  = s.d;
            in_eol   = s.eol;
            mode     = s.mode;
            in_valid = 1'b1;
         end
         out_ready = ($urandom_range(0, 99) < rpct);
         #1;
         if (hold_pend) begin
            chk(out_valid && out_data == hold_d && {out_odd, out_bytes} == hold_side,
                "R9", "stalled word changed", out_data, hold_d);
            hold_pend = 0;
         end
         if (out_valid)
            chk(!in_ready, "R9", "in_ready while word waits", 64'(in_ready), 64'd0);
         if (out_valid && !out_ready) begin
            hold_pend = 1;
            hold_d    = out_data;
            hold_side = {out_odd, out_bytes};
         end
         if (in_valid && in_ready) begin
            model_accept(in_data, in_eol, mode);
            took = 1;
         end
         if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R6", "unexpected output word", out_data, 64'd0);
            end else begin
               e = exp_q.pop_front();
               chk(out_odd == e.odd, "R7", "row parity", 64'(out_odd), 64'(e.odd));
               chk(out_data == e.d, e.tag, "packed data (R2 lane)", out_data, e.d);
               chk(int'(out_bytes) == e.nb, (e.nb == 8) ? "R6" : "R8", "byte count",
                   64'(out_bytes), 64'(e.nb));
               chk(out_last == e.last, "R8", "last flag", 64'(out_last), 64'(e.last));
            end
         end
         if (stim_q.size() == 0 && !in_valid && exp_q.size() == 0 && !out_valid) idle++;
         else idle = 0;
         if (idle > 4) break;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int lines;
      process::self().srandom(32'h5EED_0421);
      rst_n     = 1'b0;
      in_valid  = 1'b0;
      in_data   = '0;
      in_eol    = 1'b0;
      mode      = 2'b00;
      out_ready = 1'b0;
      repeat (3) @(negedge clk);
      chk(!out_valid && in_ready, "R1", "state during reset",
          {62'd0, out_valid, in_ready}, 64'd1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!out_valid && in_ready, "R1", "state after reset",
          {62'd0, out_valid, in_ready}, 64'd1);

      // R4: single 12-bit word, high slot bits set, short flush of 3 bytes
      push_stim(64'hF789_E456_F123_FABC, 1'b1, 2'b01);
      // R3: two 14-bit words give exactly eight bytes at line end
      push_stim(64'hFFFF_C001_BFFF_4000, 1'b0, 2'b00);
      push_stim(64'h1234_5678_9ABC_DEF0, 1'b1, 2'b11);
      // R5: three 10-bit words give one full and one single-byte word
      for (int i = 0; i < 3; i++)
         push_stim({16'hFC00 | 16'(i), 16'h03FF, 16'h0155 + 16'(i), 16'hFEAA}, i == 2, 2'b10);
      // R8: 12-bit line where the flush lands on exactly 8 after 24 bytes
      for (int i = 0; i < 8; i++)
         push_stim({$urandom(), $urandom()}, i == 7, 2'b01);
      // R8: 14-bit line ending on 12 bytes: full word then 4-byte word
      for (int i = 0; i < 3; i++)
         push_stim({$urandom(), $urandom()}, i == 2, 2'b00);
      run(100, 100, 2000);

      lines = 0;
      while (lines < 120) begin
         logic [1:0] m;
         int         len;
         m   = 2'($urandom_range(0, 3));
         len = $urandom_range(1, 9);
         for (int i = 0; i < len; i++)
            push_stim({$urandom(), $urandom()}, i == len - 1, m);
         lines++;
      end
      run(70, 60, 60000);
      run(100, 100, 2000);

      chk(exp_q.size() == 0 && stim_q.size() == 0, "R8", "words left undelivered",
          64'(exp_q.size()), 64'd0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule